// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits beside a core's private cache and tracks a single reservation for load-linked / store-conditional atomic sequences. A load-linked request records the cache-line address it touched and arms the reservation. A later store-conditional is granted only if that reservation is still armed and names the same line. Otherwise it is refused, and the store never reaches the cache.

The reservation is lost whenever the line could have been changed by another agent or has left the cache. That happens on a coherence invalidation of the linked line or a local eviction of it. Success is decided only by whether the reservation survived. Memory contents are never compared. Every store-conditional uses up the reservation, whether it wins or loses. The verdict is registered and appears one cycle after the request. It comes with a commit enable that the cache uses to perform the store.

Top module: `llsc_resv_monitor`

## Requirements
- R1: After reset no reservation is held, and `sc_done`, `sc_ok` and `sc_commit` are 0.
- R2: A store-conditional to the line of a held reservation succeeds. `sc_done`=1, `sc_ok`=1 and `sc_commit`=1 in the cycle after the request. The line is the address with its low `log2(LINE_BYTES)` bits (6 bits for 64-byte lines) ignored.
- R3: A store-conditional with no reservation held fails. `sc_done`=1, `sc_ok`=0 and `sc_commit`=0 in the next cycle.
- R4: An invalidation whose line equals the linked line clears the reservation.
- R5: An eviction whose line equals the linked line clears the reservation.
- R6: An invalidation or eviction of any other line leaves the reservation intact.
- R7: Every store-conditional clears the reservation, whether it succeeds or fails. A second one with no load-linked in between fails.
- R8: A new load-linked replaces any earlier reservation. Only the most recent line can succeed.
- R9: A store-conditional whose line differs from the linked line fails, even while the reservation is held.
- R10: An invalidation or eviction of the linked line in the same cycle as a store-conditional makes that store-conditional fail.
- R11: `sc_done` is 1 exactly in the cycle after each store-conditional request. `sc_commit` is 1 only with `sc_ok` and `sc_done`, so a failing store-conditional never asks for the write.
- R12: A load-linked in the same cycle as an invalidation of its own line, or as a store-conditional, still leaves a reservation on the load-linked line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ll_valid | input | 1 | Load-linked request |
| ll_addr | input | ADDR_W | Load-linked byte address |
| sc_valid | input | 1 | Store-conditional request |
| sc_addr | input | ADDR_W | Store-conditional byte address |
| inv_valid | input | 1 | Coherence invalidation |
| inv_addr | input | ADDR_W | Invalidated address |
| evict_valid | input | 1 | Local cache eviction |
| evict_addr | input | ADDR_W | Evicted address |
| sc_done | output | 1 | Store-conditional verdict valid (one cycle after request) |
| sc_ok | output | 1 | Store-conditional result: 1 success, 0 failure |
| sc_commit | output | 1 | Enable for the cache to perform the store |

## Verification
The bound checker checks these properties on every cycle:
- each request gets exactly one verdict one cycle later;
- the commit enable never appears without success;
- a store-conditional that meets a same-line invalidation or eviction is refused;
- back-to-back store-conditionals with no load-linked in between are refused.

Whether the reservation survives a sequence needs the bench's scenarios. These include line-granular matching across different byte offsets, snoops to unrelated lines, overwriting by a newer load-linked, and the load-linked-wins collisions. The bench checks them through the scoreboarded verdicts.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef struct packed {
    logic done;
    logic ok;
    logic commit;
  } sc_resp_t;

  localparam int PROBE_SC    = 0;
  localparam int PROBE_INV   = 1;
  localparam int PROBE_EVICT = 2;
  localparam int NUM_PROBES  = 3;
endpackage

// File: rtl/line_match.sv
module line_match #(
  parameter int ADDR_W = 40,
  parameter int OFF_W  = 6,
  localparam int LINE_W = ADDR_W - OFF_W
) (
  input  logic              probe_valid,
  input  logic [ADDR_W-1:0] probe_addr,
  input  logic              link_valid,
  input  logic [LINE_W-1:0] link_line,
  output logic              hit
);
  always_comb begin
    hit = probe_valid && link_valid && (probe_addr[ADDR_W-1:OFF_W] == link_line);
  end
endmodule

// File: rtl/link_reg.sv
module link_reg #(
  parameter int LINE_W = 34
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set,
  input  logic [LINE_W-1:0] set_line,
  input  logic              clr,
  output logic              link_valid,
  output logic [LINE_W-1:0] link_line
);
  always_ff @(posedge clk) begin
    if (rst) begin
      link_valid <= 1'b0;
      link_line  <= '0;
    end else if (set) begin
      link_valid <= 1'b1;
      link_line  <= set_line;
    end else if (clr) begin
      link_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/sc_judge.sv
module sc_judge
  import llsc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     sc_valid,
  input  logic     sc_hit,
  input  logic     snoop_kill,
  output sc_resp_t resp
);
  logic win;

  always_comb begin
    win = sc_valid && sc_hit && !snoop_kill;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resp <= '0;
    end else begin
      resp.done   <= sc_valid;
      resp.ok     <= win;
      resp.commit <= win;
    end
  end
endmodule

// File: rtl/llsc_resv_monitor.sv
module llsc_resv_monitor
  import llsc_pkg::*;
#(
  parameter int ADDR_W     = 40,
  parameter int LINE_BYTES = 64,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int LINE_W = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ll_valid,
  input  logic [ADDR_W-1:0] ll_addr,
  input  logic              sc_valid,
  input  logic [ADDR_W-1:0] sc_addr,
  input  logic              inv_valid,
  input  logic [ADDR_W-1:0] inv_addr,
  input  logic              evict_valid,
  input  logic [ADDR_W-1:0] evict_addr,
  output logic              sc_done,
  output logic              sc_ok,
  output logic              sc_commit
);
  logic              link_valid;
  logic [LINE_W-1:0] link_line;
  logic [NUM_PROBES-1:0]             probe_valid;
  logic [NUM_PROBES-1:0][ADDR_W-1:0] probe_addr;
  logic [NUM_PROBES-1:0]             probe_hit;
  logic              snoop_kill;
  logic              link_clr;
  sc_resp_t          resp;

  always_comb begin
    probe_valid[PROBE_SC]    = sc_valid;
    probe_addr[PROBE_SC]     = sc_addr;
    probe_valid[PROBE_INV]   = inv_valid;
    probe_addr[PROBE_INV]    = inv_addr;
    probe_valid[PROBE_EVICT] = evict_valid;
    probe_addr[PROBE_EVICT]  = evict_addr;
  end

  for (genvar g = 0; g < NUM_PROBES; g++) begin : g_probe
    line_match #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_match (
      .probe_valid (probe_valid[g]),
      .probe_addr  (probe_addr[g]),
      .link_valid  (link_valid),
      .link_line   (link_line),
      .hit         (probe_hit[g])
    );
  end

  always_comb begin
    snoop_kill = probe_hit[PROBE_INV] || probe_hit[PROBE_EVICT];
    link_clr   = sc_valid || snoop_kill;
  end

  link_reg #(.LINE_W(LINE_W)) u_link (
    .clk        (clk),
    .rst        (rst),
    .set        (ll_valid),
    .set_line   (ll_addr[ADDR_W-1:OFF_W]),
    .clr        (link_clr),
    .link_valid (link_valid),
    .link_line  (link_line)
  );

  sc_judge u_judge (
    .clk        (clk),
    .rst        (rst),
    .sc_valid   (sc_valid),
    .sc_hit     (probe_hit[PROBE_SC]),
    .snoop_kill (snoop_kill),
    .resp       (resp)
  );

  always_comb begin
    sc_done   = resp.done;
    sc_ok     = resp.ok;
    sc_commit = resp.commit;
  end
endmodule

// File: rtl/llsc_resv_checker.sv
module llsc_resv_checker #(
  parameter int ADDR_W = 40,
  parameter int OFF_W  = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              ll_valid,
  input logic              sc_valid,
  input logic [ADDR_W-1:0] sc_addr,
  input logic              inv_valid,
  input logic [ADDR_W-1:0] inv_addr,
  input logic              evict_valid,
  input logic [ADDR_W-1:0] evict_addr,
  input logic              sc_done,
  input logic              sc_ok,
  input logic              sc_commit
);
  p_commit_gated_r11: assert property (@(posedge clk) disable iff (rst)
    sc_commit |-> (sc_ok && sc_done));

  p_ok_needs_done_r11: assert property (@(posedge clk) disable iff (rst)
    sc_ok |-> sc_done);

  p_verdict_follows_req_r11: assert property (@(posedge clk) disable iff (rst)
    sc_valid |=> sc_done);

  p_no_spurious_verdict_r11: assert property (@(posedge clk) disable iff (rst)
    !sc_valid |=> !sc_done);

  p_inv_collision_fails_r10: assert property (@(posedge clk) disable iff (rst)
    (sc_valid && inv_valid && (inv_addr[ADDR_W-1:OFF_W] == sc_addr[ADDR_W-1:OFF_W]))
      |=> !sc_ok);

  p_evict_collision_fails_r5: assert property (@(posedge clk) disable iff (rst)
    (sc_valid && evict_valid && (evict_addr[ADDR_W-1:OFF_W] == sc_addr[ADDR_W-1:OFF_W]))
      |=> !sc_ok);

  p_sc_consumes_link_r7: assert property (@(posedge clk) disable iff (rst)
    (sc_valid && $past(sc_valid) && !$past(ll_valid)) |=> !sc_ok);
endmodule

bind llsc_resv_monitor llsc_resv_checker #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ll_valid    (ll_valid),
  .sc_valid    (sc_valid),
  .sc_addr     (sc_addr),
  .inv_valid   (inv_valid),
  .inv_addr    (inv_addr),
  .evict_valid (evict_valid),
  .evict_addr  (evict_addr),
  .sc_done     (sc_done),
  .sc_ok       (sc_ok),
  .sc_commit   (sc_commit)
);

// File: tb/sim_llsc_resv_monitor.sv
`timescale 1ns/1ps
module sim_llsc_resv_monitor;
  localparam int AW = 40;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ll_valid = 1'b0, sc_valid = 1'b0, inv_valid = 1'b0, evict_valid = 1'b0;
  logic [AW-1:0] ll_addr = '0, sc_addr = '0, inv_addr = '0, evict_addr = '0;
  logic          sc_done, sc_ok, sc_commit;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;
  bit exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  llsc_resv_monitor #(.ADDR_W(AW), .LINE_BYTES(64)) u0 (
    .clk(clk), .rst(rst),
    .ll_valid(ll_valid), .ll_addr(ll_addr),
    .sc_valid(sc_valid), .sc_addr(sc_addr),
    .inv_valid(inv_valid), .inv_addr(inv_addr),
    .evict_valid(evict_valid), .evict_addr(evict_addr),
    .sc_done(sc_done), .sc_ok(sc_ok), .sc_commit(sc_commit)
  );

  // one cycle of stimulus; an SC pushes its expected verdict
  task automatic step(input bit ll, input logic [AW-1:0] la,
                      input bit sc, input logic [AW-1:0] sa,
                      input bit iv, input logic [AW-1:0] ia,
                      input bit ev, input logic [AW-1:0] ea,
                      input bit exp_ok, input string tag);
    @(negedge clk);
    ll_valid = ll; ll_addr = la;
    sc_valid = sc; sc_addr = sa;
    inv_valid = iv; inv_addr = ia;
    evict_valid = ev; evict_addr = ea;
    if (sc) begin
      exp_q.push_back(exp_ok);
      tag_q.push_back(tag);
    end
    @(negedge clk);
    ll_valid = 0; sc_valid = 0; inv_valid = 0; evict_valid = 0;
  endtask

  task automatic do_ll(input logic [AW-1:0] a);
    step(1, a, 0, '0, 0, '0, 0, '0, 0, "");
  endtask

  task automatic do_sc(input logic [AW-1:0] a, input bit e, input string tag);
    step(0, '0, 1, a, 0, '0, 0, '0, e, tag);
  endtask

  // monitor: pops expectations as verdicts appear
  always @(negedge clk) begin
    if (!rst && sc_done) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R11: verdict with no request, got done=1 expected done=0");
      end else begin
        bit e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        total++;
        if (sc_ok !== e || sc_commit !== e) begin
          bad++;
          $display("FAIL %s: ok=%0b commit=%0b expected %0b", t, sc_ok, sc_commit, e);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  localparam logic [AW-1:0] A0 = 40'h10_0000_1000;
  localparam logic [AW-1:0] A1 = 40'h10_0000_1038; // same line as A0
  localparam logic [AW-1:0] B0 = 40'h10_0000_1040; // next line

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (sc_done !== 0 || sc_ok !== 0 || sc_commit !== 0) begin
      bad++;
      $display("FAIL R1: outputs %0b%0b%0b expected 000", sc_done, sc_ok, sc_commit);
    end
    @(negedge clk); rst = 0;

    do_sc(A0, 0, "R1 no link after reset");
    do_ll(A0); do_sc(A1, 1, "R2 same line other offset");
    do_sc(A0, 0, "R3 no link");
    do_ll(A0); do_sc(A0, 1, "R7 first sc");
    do_sc(A0, 0, "R7 second sc");
    do_ll(A0); step(0, '0, 0, '0, 1, A1, 0, '0, 0, ""); do_sc(A0, 0, "R4 invalidate");
    do_ll(A0); step(0, '0, 0, '0, 0, '0, 1, A1, 0, ""); do_sc(A0, 0, "R5 evict");
    do_ll(A0); step(0, '0, 0, '0, 1, B0, 1, B0, 0, ""); do_sc(A0, 1, "R6 other line snoop");
    do_ll(A0); do_ll(B0); do_sc(A0, 0, "R8 old line after new ll");
    do_ll(A0); do_ll(B0); do_sc(B0, 1, "R8 new line");
    do_ll(A0); do_sc(B0, 0, "R9 mismatch");
    do_sc(A0, 0, "R9 mismatch consumed link");
    do_ll(A0); step(0, '0, 1, A0, 1, A1, 0, '0, 0, "R10 inv collision");
    do_ll(A0); step(0, '0, 1, A0, 0, '0, 1, A0, 0, "R10 evict collision");
    step(1, A0, 0, '0, 1, A0, 0, '0, 0, ""); do_sc(A0, 1, "R12 ll wins over inv");
    do_ll(B0); step(1, A0, 1, A0, 0, '0, 0, '0, 0, "R12 sc beside ll");
    do_sc(A0, 1, "R12 ll wins over sc");

    repeat (3) @(negedge clk);
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R11: %0d verdicts missing, expected 0", exp_q.size());
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule